// File: doc/BRIEF.md
# Timer Channel Interrupt Enable/Status Register

This block gathers the interrupt state of five timer channels into one 32-bit register and drives one interrupt line per channel. Each channel supplies a single-cycle expiry pulse. Every expiry latches a status flag, whether or not interrupts are enabled for that channel. The interrupt line goes high only when the expiry arrives while the channel's enable bit is already set.

Software reaches the register through a plain write strobe with write data and a continuously valid read word. Within that register, the enable bits are ordinary read/write bits. The status bits clear when a one is written to them, and a zero written to a status bit leaves it as it was. An interrupt line stays high until software clears the matching status bit. Setting the enable bit later does not raise an interrupt for an expiry that has already happened.

Top module: `tmr_irq_cstat`

## Requirements
- R1: After a synchronous reset, the read word is 0 and every interrupt line is low.
- R2: On a write, enable bits [4:0] (bit i belongs to channel i) take the written bits [4:0]. The new value can be read back in the cycle after the write.
- R3: On a write, a 1 in bit 5+i clears the status of channel i, and a 0 leaves that status unchanged. Status bits are read at [9:5].
- R4: An expiry pulse on channel i sets status bit 5+i in the following cycle, whether or not channel i is enabled.
- R5: Interrupt line i goes high in the cycle after an expiry on channel i only if enable bit i was set before that cycle's edge. An enable written in the same cycle as the expiry does not count.
- R6: An interrupt line falls only when a write clears its status bit. Writing the enable bit, whether setting or clearing it, leaves the line unchanged.
- R7: If an expiry and a clearing write hit the same channel in the same cycle, the status ends up set.
- R8: Read bits [31:10] are always 0, and writes to those bits have no effect.
- R9: An interrupt line that is high always has its status bit set, and it stays high until that status is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| expiry | input | 5 | Single-cycle expiry pulse, one bit per channel |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register value |
| irq | output | 5 | Level interrupt line, one per channel |

## Verification
The main stimulus table walks the register through several patterns, each aimed at one distinction:
- expiries on a mix of enabled and disabled channels, which separates status latching from interrupt raising;
- clears that target a raised line and clears that target a status with no line, which show the line drops only on a clear;
- late enabling, which shows that it never raises a line;
- an expiry colliding with a clear of the same channel, which shows that set wins;
- all-ones writes to the unused bits, which show they stay at zero.

Directed cases then cover a mid-run reset, and an expiry that arrives together with the write that first enables its channel, which must set status without raising the line.

// File: rtl/tic_pkg.sv
package tic_pkg;

    localparam int unsigned N_CH   = 5;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ST_LO  = N_CH;
    localparam int unsigned USED_W = 2 * N_CH;

    // Per-channel command decoded from one register write.
    typedef struct packed {
        logic wr;       // a write happened this cycle
        logic en_val;   // new enable value
        logic st_clr;   // clear request for status
    } chan_cmd_t;

    // Per-channel stored state.
    typedef struct packed {
        logic en;
        logic st;
        logic irq;
    } chan_state_t;

    function automatic chan_cmd_t make_cmd(input logic wr,
                                           input logic en_bit,
                                           input logic clr_bit);
        chan_cmd_t c;
        c.wr     = wr;
        c.en_val = en_bit;
        c.st_clr = wr & clr_bit;
        return c;
    endfunction

endpackage

// File: rtl/tic_wr_decode.sv
module tic_wr_decode
    import tic_pkg::*;
#(
    parameter int unsigned NCH = N_CH,
    parameter int unsigned DW  = DATA_W
) (
    input  logic                     wr_en,
    input  logic [DW-1:0]            wr_data,
    output chan_cmd_t [NCH-1:0]      cmd
);
    localparam int unsigned STL = NCH;

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        assign cmd[i] = make_cmd(wr_en, wr_data[i], wr_data[STL+i]);
    end

    // Bits above the status field are not decoded and so cannot change anything.
    logic unused_hi;
    assign unused_hi = ^wr_data[DW-1:2*NCH];

endmodule

// File: rtl/tic_chan.sv
module tic_chan
    import tic_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        expiry,
    input  chan_cmd_t   cmd,
    output chan_state_t state
);
    chan_state_t q, d;

    always_comb begin
        d = q;
        if (cmd.wr) d.en = cmd.en_val;
        // Status: a set from expiry takes priority over a clear.
        if (expiry)          d.st = 1'b1;
        else if (cmd.st_clr) d.st = 1'b0;
        // Line: raised on an expiry while enabled (value before the write); dropped on an effective clear.
        if (expiry && q.en)                d.irq = 1'b1;
        else if (!expiry && cmd.st_clr)    d.irq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign state = q;

endmodule

// File: rtl/tmr_irq_cstat.sv
module tmr_irq_cstat
    import tic_pkg::*;
#(
    parameter int unsigned NCH = N_CH,
    parameter int unsigned DW  = DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] expiry,
    input  logic           wr_en,
    input  logic [DW-1:0]  wr_data,
    output logic [DW-1:0]  rd_data,
    output logic [NCH-1:0] irq
);
    localparam int unsigned UW = 2 * NCH;

    chan_cmd_t   [NCH-1:0] cmd;
    chan_state_t [NCH-1:0] st;
    logic        [NCH-1:0] en_v, st_v;

    tic_wr_decode #(.NCH(NCH), .DW(DW)) u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tic_chan u_ch (
            .clk    (clk),
            .rst    (rst),
            .expiry (expiry[i]),
            .cmd    (cmd[i]),
            .state  (st[i])
        );
        assign en_v[i] = st[i].en;
        assign st_v[i] = st[i].st;
        assign irq[i]  = st[i].irq;
    end

    assign rd_data = {{(DW-UW){1'b0}}, st_v, en_v};

endmodule

// File: rtl/tic_checker.sv
module tic_checker #(
    parameter int unsigned NCH = 5,
    parameter int unsigned DW  = 32
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] expiry,
    input logic           wr_en,
    input logic [DW-1:0]  wr_data,
    input logic [DW-1:0]  rd_data,
    input logic [NCH-1:0] irq
);
    assert_hi_zero_R8: assert property (@(posedge clk) disable iff (rst)
        rd_data[DW-1:2*NCH] == '0);

    for (genvar i = 0; i < NCH; i++) begin : g_a
        assert_en_write_R2: assert property (@(posedge clk) disable iff (rst)
            wr_en |=> rd_data[i] == $past(wr_data[i]));
        assert_st_set_R4: assert property (@(posedge clk) disable iff (rst)
            expiry[i] |=> rd_data[NCH+i]);
        assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
            (expiry[i] && wr_en && wr_data[NCH+i]) |=> rd_data[NCH+i]);
        assert_irq_rise_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[i]) |-> $past(expiry[i] && rd_data[i]));
        assert_irq_fall_R6: assert property (@(posedge clk) disable iff (rst)
            $fell(irq[i]) |-> $past(wr_en && wr_data[NCH+i]));
        assert_irq_has_st_R9: assert property (@(posedge clk) disable iff (rst)
            irq[i] |-> rd_data[NCH+i]);
    end
endmodule

bind tmr_irq_cstat tic_checker #(.NCH(NCH), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .expiry(expiry), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
);

// File: tb/sim_tmr_irq_cstat.sv
module sim_tmr_irq_cstat;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  expiry = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [4:0]  irq;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    tmr_irq_cstat u0 (
        .clk(clk), .rst(rst), .expiry(expiry), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    localparam int NV = 9;
    localparam logic [4:0]  V_EXP [NV] = '{5'h00, 5'h07, 5'h00, 5'h00, 5'h00, 5'h18, 5'h00, 5'h01, 5'h00};
    localparam logic        V_WR  [NV] = '{1'b1,  1'b0,  1'b1,  1'b1,  1'b1,  1'b1,  1'b1,  1'b0,  1'b1};
    localparam logic [31:0] V_WD  [NV] = '{32'h005, 32'h0, 32'h045, 32'h01F, 32'h03F, 32'h19F,
                                           32'hFFFF_FC00, 32'h0, 32'h3E0};
    localparam logic [31:0] V_RD  [NV] = '{32'h005, 32'h0E5, 32'h0A5, 32'h0BF, 32'h09F, 32'h31F,
                                           32'h300, 32'h320, 32'h000};
    localparam logic [4:0]  V_IRQ [NV] = '{5'h00, 5'h05, 5'h05, 5'h05, 5'h04, 5'h18, 5'h18, 5'h18, 5'h00};
    string v_tag [NV] = '{"R2", "R4/R5", "R3/R9", "R6", "R3/R6", "R7/R5",
                          "R8/R6", "R4/R5", "R3/R6"};

    task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [4:0] e, input logic w, input logic [31:0] d);
        expiry = e; wr_en = w; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        expiry = '0; wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk32("R1 rd", rd_data, 32'h0);
        chk32("R1 irq", {27'b0, irq}, 32'h0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            step(V_EXP[k], V_WR[k], V_WD[k]);
            chk32({v_tag[k], " rd"}, rd_data, V_RD[k]);
            chk32({v_tag[k], " irq"}, {27'b0, irq}, {27'b0, V_IRQ[k]});
        end

        // R5: an enable written in the expiry's own cycle does not raise the line.
        step(5'h02, 1'b1, 32'h002);
        chk32("R5 same-cycle rd", rd_data, 32'h042);
        chk32("R5 same-cycle irq", {27'b0, irq}, 32'h0);

        // R1: reset in mid-run returns everything to zero.
        step(5'h02, 1'b0, 32'h0);
        chk32("R5 pre-reset irq", {27'b0, irq}, 32'h02);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk32("R1 mid rd", rd_data, 32'h0);
        chk32("R1 mid irq", {27'b0, irq}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule